// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides who drives the command interface of a security coprocessor: the local host, reached through a byte-wide register bus, or one external requester, which raises a level request input. The host sees a single access byte at offset zero. It writes action bits into this byte to request ownership, give ownership up or take ownership by force. It reads the same byte back to learn whether it owns the interface, whether the other side is waiting, and whether the byte can be trusted yet.

After reset the block stays in a settling phase for a set number of clocks. During that phase the whole byte reads zero and writes have no effect. The state machine then moves through four named states:

- `ST_SETTLE`: after reset, the valid flag is low.
- `ST_IDLE`: nobody owns the interface.
- `ST_HOST`: the host owns it.
- `ST_EXT`: the external requester owns it.

The transitions are:

- settle done: `ST_SETTLE`→`ST_IDLE`.
- host grant: `ST_IDLE`→`ST_HOST` on a request write.
- external grant: `ST_IDLE`→`ST_EXT` when `ext_req` is high and there is no host request.
- release: `ST_HOST`→`ST_IDLE`, or `ST_HOST`→`ST_EXT` when the external side waits.
- seize: `ST_EXT`→`ST_HOST` on a seize write.
- hand-back: `ST_EXT`→`ST_HOST` when `ext_req` falls with a host request queued.
- drop: `ST_EXT`→`ST_IDLE` when `ext_req` falls with no host request queued.

Top module: `loc_arb_top`

## Requirements
- R1: After reset the access byte reads 0x00 and writes are ignored for at least SETTLE_CYC clocks. After that the valid bit (bit 7) reads 1.
- R2: Read layout: bit 0 = `est_flag` input, bit 1 = host request queued, bit 2 = external requester waiting while the host owns, bit 3 = 0, bit 4 = seized, bit 5 = host owns, bit 6 = 0, bit 7 = valid. `bus_rdata` updates in the cycle after a `bus_rd` strobe. A read of any other address returns 0x00.
- R3: Writing a 1 to bit 1 while the locality is free makes `host_active` 1 one cycle after the write, and the byte reads 0xA0.
- R4: Writing a 1 to bit 5 while the host owns releases ownership on the next cycle. Ownership passes to the external side if `ext_req` is high; otherwise the locality becomes free.
- R5: While the host owns and `ext_req` is high, bit 2 reads 1 and the host keeps ownership until it releases.
- R6: A request write while the external side owns sets bit 1 and leaves `host_active` low. The host is granted one cycle after `ext_req` falls.
- R7: Writing a 1 to bit 3 while the external side owns moves ownership to the host on the next cycle, drops `ext_grant` and sets bit 4. Bit 4 clears on the next grant of either side.
- R8: A request write while the host already owns changes nothing.
- R9: Writes to bits 0, 2, 4 and 7 are ignored. Writes to other addresses are ignored. A seize write is ignored unless the external side owns.
- R10: When the locality is free, a high `ext_req` gives `ext_grant` one cycle later. A host request in the same cycle wins.
- R11: Writing a 1 to bit 5 while the host does not own cancels a queued host request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered |
| ext_req | input | 1 | External requester wants the locality |
| est_flag | input | 1 | Establishment indication shown in bit 0 |
| host_active | output | 1 | Host owns the command interface |
| ext_grant | output | 1 | External requester owns the command interface |

## Verification
Every ownership change becomes visible at `host_active` and `ext_grant` after the first clock edge that samples the write strobe or the change of `ext_req`. Read data arrives after the first edge that samples `bus_rd`. The bench drives all inputs on the falling edge and holds them for one full cycle. It samples the outputs on the next falling edge, so each result is read half a cycle after the edge that produced it. For the settling phase, the bench reads zero well inside the window and reads the valid flag only after SETTLE_CYC plus a margin.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_IDLE   = 2'd1,
        ST_HOST   = 2'd2,
        ST_EXT    = 2'd3
    } arb_state_e;

    localparam int B_EST    = 0;
    localparam int B_REQ    = 1;
    localparam int B_PEND   = 2;
    localparam int B_SEIZE  = 3;
    localparam int B_SEIZED = 4;
    localparam int B_ACT    = 5;
    localparam int B_VALID  = 7;

endpackage

// File: rtl/loc_arb_settle.sv
module loc_arb_settle #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic settled
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign settled = (cnt_q == LIMIT);

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        settled |=> settled); // R1
endmodule

// File: rtl/loc_arb_regif.sv
module loc_arb_regif
    import loc_arb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ACC_OFS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              valid,
    input  logic              est_flag,
    input  logic              req_queued,
    input  logic              pend,
    input  logic              seized,
    input  logic              host_own,
    output logic              cmd_req,
    output logic              cmd_rel,
    output logic              cmd_seize
);
    logic       hit;
    logic       wr_ok;
    logic [7:0] view;
    logic [7:0] rdata_q;

    assign hit   = (bus_addr == ACC_OFS);
    assign wr_ok = bus_wr && hit && valid;

    always_comb begin
        cmd_req   = wr_ok && bus_wdata[B_REQ];
        cmd_rel   = wr_ok && bus_wdata[B_ACT];
        cmd_seize = wr_ok && bus_wdata[B_SEIZE];
    end

    always_comb begin
        view = '0;
        if (valid) begin
            view[B_EST]    = est_flag;
            view[B_REQ]    = req_queued;
            view[B_PEND]   = pend;
            view[B_SEIZED] = seized;
            view[B_ACT]    = host_own;
            view[B_VALID]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= hit ? view : 8'h00;
        end
    end

    assign bus_rdata = rdata_q;

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R2
endmodule

// File: rtl/loc_arb_fsm.sv
module loc_arb_fsm
    import loc_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid_in,
    input  logic ext_req,
    input  logic cmd_req,
    input  logic cmd_rel,
    input  logic cmd_seize,
    output logic valid,
    output logic host_active,
    output logic ext_grant,
    output logic req_queued,
    output logic pend,
    output logic seized
);
    arb_state_e state_q, state_d;
    logic       reqq_q, reqq_d;
    logic       seized_q, seized_d;
    logic       by_seize;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_SETTLE;
            reqq_q   <= 1'b0;
            seized_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            reqq_q   <= reqq_d;
            seized_q <= seized_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        reqq_d   = reqq_q;
        by_seize = 1'b0;
        unique case (state_q)
            ST_SETTLE: begin
                if (valid_in) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (cmd_req)      state_d = ST_HOST;
                else if (ext_req) state_d = ST_EXT;
            end
            ST_HOST: begin
                if (cmd_rel) state_d = ext_req ? ST_EXT : ST_IDLE;
            end
            ST_EXT: begin
                if (cmd_seize) begin
                    state_d  = ST_HOST;
                    by_seize = 1'b1;
                    reqq_d   = 1'b0;
                end else if (!ext_req) begin
                    state_d = (reqq_q || cmd_req) ? ST_HOST : ST_IDLE;
                    reqq_d  = 1'b0;
                end else if (cmd_rel) begin
                    reqq_d = 1'b0;
                end else if (cmd_req) begin
                    reqq_d = 1'b1;
                end
            end
            default: state_d = ST_SETTLE;
        endcase
    end

    always_comb begin
        seized_d = seized_q;
        if (by_seize) begin
            seized_d = 1'b1;
        end else if (state_d != state_q &&
                     (state_d == ST_HOST || state_d == ST_EXT)) begin
            seized_d = 1'b0;
        end
    end

    always_comb begin
        valid       = (state_q != ST_SETTLE);
        host_active = (state_q == ST_HOST);
        ext_grant   = (state_q == ST_EXT);
        req_queued  = reqq_q;
        pend        = (state_q == ST_HOST) && ext_req;
        seized      = seized_q;
    end

    AST_SETTLE_NOGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!host_active && !ext_grant)); // R1
    AST_REQ_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_req) |=> host_active); // R3
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_active && cmd_rel) |=> !host_active); // R4
    AST_HOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_active && !cmd_rel) |=> host_active); // R5
    AST_SEIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_grant && cmd_seize) |=> (host_active && seized)); // R7
endmodule

// File: rtl/loc_arb_top.sv
module loc_arb_top
    import loc_arb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SETTLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              ext_req,
    input  logic              est_flag,
    output logic              host_active,
    output logic              ext_grant
);
    logic settled, valid, req_queued, pend, seized;
    logic cmd_req, cmd_rel, cmd_seize;

    loc_arb_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .settled(settled)
    );

    loc_arb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .valid_in(settled), .ext_req(ext_req),
        .cmd_req(cmd_req), .cmd_rel(cmd_rel), .cmd_seize(cmd_seize),
        .valid(valid), .host_active(host_active), .ext_grant(ext_grant),
        .req_queued(req_queued), .pend(pend), .seized(seized)
    );

    loc_arb_regif #(.ADDR_W(ADDR_W), .ACC_OFS('0)) u_regif (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .valid(valid), .est_flag(est_flag), .req_queued(req_queued),
        .pend(pend), .seized(seized), .host_own(host_active),
        .cmd_req(cmd_req), .cmd_rel(cmd_rel), .cmd_seize(cmd_seize)
    );
endmodule

// File: tb/sim_loc_arb_top.sv
module sim_loc_arb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       ext_req = 1'b0;
    logic       est_flag = 1'b0;
    logic       host_active, ext_grant;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    loc_arb_top #(.ADDR_W(8), .SETTLE_CYC(16)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ext_req(ext_req), .est_flag(est_flag),
        .host_active(host_active), .ext_grant(ext_grant)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = '0;
        d = bus_rdata;
    endtask

    task automatic set_ext(input logic v);
        @(negedge clk);
        ext_req = v;
        @(negedge clk);
    endtask

    task automatic own(input string tag, input logic h, input logic e);
        chk({tag, " host_active"}, {7'd0, host_active}, {7'd0, h});
        chk({tag, " ext_grant"}, {7'd0, ext_grant}, {7'd0, e});
    endtask

    task automatic t_settle();
        logic [7:0] d;
        chk("R1 reset rdata", bus_rdata, 8'h00);
        rd(8'h00, d);
        chk("R1 byte in settle", d, 8'h00);
        wr(8'h00, 8'h02);
        own("R1 write in settle", 1'b0, 1'b0);
        repeat (24) @(negedge clk);
        rd(8'h00, d);
        chk("R1 valid after settle", d, 8'h80);
        own("R1 after settle", 1'b0, 1'b0);
    endtask

    task automatic t_grant();
        logic [7:0] d;
        wr(8'h00, 8'h02);
        own("R3 grant", 1'b1, 1'b0);
        rd(8'h00, d);
        chk("R3 R2 byte after grant", d, 8'hA0);
        wr(8'h00, 8'h02);
        rd(8'h00, d);
        chk("R8 repeat request", d, 8'hA0);
        wr(8'h00, 8'h95);
        rd(8'h00, d);
        chk("R9 read-only bits", d, 8'hA0);
        wr(8'h00, 8'h08);
        rd(8'h00, d);
        chk("R9 seize while owner", d, 8'hA0);
    endtask

    task automatic t_contend();
        logic [7:0] d;
        set_ext(1'b1);
        own("R5 hold under contention", 1'b1, 1'b0);
        rd(8'h00, d);
        chk("R5 pending bit", d, 8'hA4);
        wr(8'h00, 8'h20);
        own("R4 release to external", 1'b0, 1'b1);
        rd(8'h00, d);
        chk("R4 byte after release", d, 8'h80);
    endtask

    task automatic t_queue();
        logic [7:0] d;
        wr(8'h00, 8'h02);
        own("R6 queued no grant", 1'b0, 1'b1);
        rd(8'h00, d);
        chk("R6 request bit", d, 8'h82);
        wr(8'h00, 8'h20);
        rd(8'h00, d);
        chk("R11 cancel queued", d, 8'h80);
        wr(8'h00, 8'h02);
        set_ext(1'b0);
        own("R6 hand-back", 1'b1, 1'b0);
        rd(8'h00, d);
        chk("R6 byte after hand-back", d, 8'hA0);
    endtask

    task automatic t_seize();
        logic [7:0] d;
        wr(8'h00, 8'h20);
        own("R4 release free", 1'b0, 1'b0);
        set_ext(1'b1);
        own("R10 external grant", 1'b0, 1'b1);
        wr(8'h00, 8'h08);
        own("R7 seize", 1'b1, 1'b0);
        rd(8'h00, d);
        chk("R7 seized bit", d, 8'hB4);
        wr(8'h00, 8'h20);
        own("R7 release after seize", 1'b0, 1'b1);
        rd(8'h00, d);
        chk("R7 seized cleared on grant", d, 8'h80);
    endtask

    task automatic t_misc();
        logic [7:0] d;
        wr(8'h01, 8'h08);
        own("R9 other address write", 1'b0, 1'b1);
        rd(8'h01, d);
        chk("R2 other address read", d, 8'h00);
        est_flag = 1'b1;
        rd(8'h00, d);
        chk("R2 establishment bit", d, 8'h81);
        est_flag = 1'b0;
        set_ext(1'b0);
        own("R10 external drop", 1'b0, 1'b0);
        @(negedge clk);
        ext_req = 1'b1; bus_addr = 8'h00; bus_wdata = 8'h02; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        own("R10 host wins tie", 1'b1, 1'b0);
        wr(8'h00, 8'h20);
        own("R10 R4 release to waiting", 1'b0, 1'b1);
        ext_req = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                t_settle();
                t_grant();
                t_contend();
                t_queue();
                t_seize();
                t_misc();
            end
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule